// File: doc/BRIEF.md
# Single-Channel Transfer Sequencer

This block is one channel of a transfer engine that moves data items between a peripheral data port and memory. Software programs four registers over a plain register bus: a control word, an item count, a peripheral base address and a memory base address. Once the channel is enabled with a nonzero count, it moves one item at a time. Each item is a read from the source side, followed by a write of the same data to the destination side. Both accesses go out on a request/ready master port.

Each side has its own access size and its own address-increment switch. Addresses are forced to the natural alignment of the access size. After every item the count steps down, and while the channel runs the count register reads back the live remaining value. In circular mode the channel reloads both the count and the addresses when the count reaches zero, and it keeps going. The channel emits single-cycle pulses at the halfway point, at completion and on a bus error. An error also switches the channel off. The priority field is exported to a separate arbiter.

Top module: `xfer_chan`

## Requirements
- R1: After reset all four registers read 0, no bus request is raised and no event pulse is emitted.
- R2: Register select 0 is control, 1 is count, 2 is peripheral base and 3 is memory base. Control bit 0 enables the channel. Bits 1, 2 and 3 enable the done, half and error pulses. Bit 4 is direction, bit 5 circular, bit 6 peripheral increment and bit 7 memory increment. Bits 9:8 hold the peripheral size, bits 11:10 the memory size and bits 13:12 the priority. Bit 14 selects memory-to-memory. Control and base registers read back what was written.
- R3: Each item is one read from the source followed by one write to the destination. With direction 0 the peripheral is the source; with direction 1 the memory is the source. The write data is the read data with every bit above the source size cleared.
- R4: Once a request is raised, the request, address, size, write flag and write data stay unchanged until ready is sampled high.
- R5: Size code 00 is 8-bit, 01 is 16-bit and 10 is 32-bit, and the size output carries the code of the side being accessed. Address bit 0 reads as 0 for 16-bit accesses, and bits 1:0 read as 0 for 32-bit accesses.
- R6: With a side's increment bit set, that side's address advances by 1, 2 or 4 bytes per item according to its size. With the bit clear, the address stays at the aligned base.
- R7: The count drops by one after each completed item. In non-circular mode the channel stops at zero, the count stays 0, the enable bit stays set and one done pulse is emitted.
- R8: A count write is ignored while the channel is enabled. While it runs, the count register reads the items still to move.
- R9: With a count of zero the channel raises no request, even when it is enabled.
- R10: With bit 14 clear, an item starts only while the peripheral request input is high. With bit 14 set, that input is not needed.
- R11: In circular mode, reaching zero reloads the last programmed count and both base addresses, emits a done pulse and continues.
- R12: An error response emits an error pulse, clears the enable bit, writes nothing for that item and leaves the count unchanged.
- R13: The half pulse fires when the count first reaches half the programmed count, rounded down. Each pulse appears only when its enable bit is set.
- R14: The priority output equals control bits 13:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| periph_req | input | 1 | Peripheral asks for an item |
| m_valid | output | 1 | Bus request |
| m_write | output | 1 | 1 for write, 0 for read |
| m_addr | output | ADDR_W | Aligned access address |
| m_size | output | 2 | Access size code |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Bus accepts the request |
| m_rdata | input | 32 | Read data, valid with ready |
| m_err | input | 1 | Error response, valid with ready |
| ev_done | output | 1 | Transfer complete pulse |
| ev_half | output | 1 | Halfway pulse |
| ev_err | output | 1 | Bus error pulse |
| prio | output | 2 | Priority for an external arbiter |

## Verification
The bench sweeps all nine combinations of peripheral and memory size from deliberately misaligned bases. A design that skips alignment or steps by the wrong stride puts the wrong addresses in the access log, and one that forgets to mask the data writes stray upper bytes. Circular runs are checked across the wrap: a channel that fails to reload would either stop after one pass or carry on from the end of the buffer. Count writes during a run and a zero count must leave the channel idle and the count untouched; a design that accepts them would restart or rewrite a live transfer. An injected read error must leave exactly the earlier items written, the count frozen and the channel disabled; a design that kept the enable bit set would carry on past the fault.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DW = 32;

  // control bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_IE_DN  = 1;
  localparam int CTL_IE_HF  = 2;
  localparam int CTL_IE_ER  = 3;
  localparam int CTL_DIR    = 4;
  localparam int CTL_CIRC   = 5;
  localparam int CTL_PINC   = 6;
  localparam int CTL_MINC   = 7;
  localparam int CTL_PSZ    = 8;
  localparam int CTL_MSZ    = 10;
  localparam int CTL_PRIO   = 12;
  localparam int CTL_M2M    = 14;
  localparam int CTL_W      = 15;

  // register selects
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_PBASE = 2'd2;
  localparam logic [1:0] SEL_MBASE = 2'd3;

  localparam int SIDE_PER = 0;
  localparam int SIDE_MEM = 1;
  localparam int N_SIDES  = 2;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'b00:   size_step = 3'd1;
      2'b01:   size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_lowmask(input logic [1:0] sz);
    case (sz)
      2'b00:   size_lowmask = 2'b00;
      2'b01:   size_lowmask = 2'b01;
      default: size_lowmask = 2'b11;
    endcase
  endfunction

  function automatic logic [DW-1:0] size_datamask(input logic [1:0] sz);
    case (sz)
      2'b00:   size_datamask = DW'(32'h0000_00FF);
      2'b01:   size_datamask = DW'(32'h0000_FFFF);
      default: size_datamask = {DW{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           sel,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  input  logic                 item_done,
  input  logic                 reload,
  input  logic                 err_stop,
  output logic [CTL_W-1:0]     ctrl,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     cnt_prog,
  output logic [ADDR_W-1:0]    pbase,
  output logic [ADDR_W-1:0]    mbase
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (sel == SEL_COUNT) && !ctrl[CTL_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      cnt      <= '0;
      cnt_prog <= '0;
      pbase    <= '0;
      mbase    <= '0;
    end else begin
      if (wr_en && sel == SEL_CTRL) ctrl <= wr_data[CTL_W-1:0];
      if (err_stop) ctrl[CTL_EN] <= 1'b0;
      if (cnt_wr) begin
        cnt      <= wr_data[CNT_W-1:0];
        cnt_prog <= wr_data[CNT_W-1:0];
      end else if (item_done) begin
        cnt <= reload ? cnt_prog : cnt - CNT_W'(1);
      end
      if (wr_en && sel == SEL_PBASE) pbase <= wr_data[ADDR_W-1:0];
      if (wr_en && sel == SEL_MBASE) mbase <= wr_data[ADDR_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rd_data = DW'(ctrl);
      SEL_COUNT: rd_data = DW'(cnt);
      SEL_PBASE: rd_data = DW'(pbase);
      default:   rd_data = DW'(mbase);
    endcase
  end

  // R8: a running channel only moves its count by completing items
  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CTL_EN] && !item_done) |=> $stable(cnt));
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              inc,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst)                 ptr <= '0;
    else if (load)           ptr <= base;
    else if (advance && inc) ptr <= ptr + ADDR_W'(size_step(size));
  end

  assign addr_o = ptr & ~ADDR_W'(size_lowmask(size));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              trig,
  input  logic              dir,
  input  logic [1:0]        psize,
  input  logic [1:0]        msize,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] maddr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cnt_prog,
  input  logic              ie_done,
  input  logic              ie_half,
  input  logic              ie_err,
  output logic              m_valid,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_err,
  output logic              item_done,
  output logic              err_hit,
  output logic              ev_done,
  output logic              ev_half,
  output logic              ev_err
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_e;
  st_e st;

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [1:0]        src_sz, dst_sz;
  logic              start;

  assign src_addr = dir ? maddr : paddr;
  assign dst_addr = dir ? paddr : maddr;
  assign src_sz   = dir ? msize : psize;
  assign dst_sz   = dir ? psize : msize;
  assign start    = en && (cnt != '0) && trig;

  assign item_done = (st == S_WR) && m_ready && !m_err;
  assign err_hit   = (st != S_IDLE) && m_ready && m_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      m_valid <= 1'b0;
      m_write <= 1'b0;
      m_addr  <= '0;
      m_size  <= '0;
      m_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_RD;
          m_valid <= 1'b1;
          m_write <= 1'b0;
          m_addr  <= src_addr;
          m_size  <= src_sz;
        end
        S_RD: if (m_ready) begin
          if (m_err) begin
            st      <= S_IDLE;
            m_valid <= 1'b0;
          end else begin
            st      <= S_WR;
            m_write <= 1'b1;
            m_addr  <= dst_addr;
            m_size  <= dst_sz;
            m_wdata <= m_rdata & size_datamask(src_sz);
          end
        end
        default: if (m_ready) begin
          st      <= S_IDLE;
          m_valid <= 1'b0;
          m_write <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_done <= 1'b0;
      ev_half <= 1'b0;
      ev_err  <= 1'b0;
    end else begin
      ev_done <= item_done && (cnt == CNT_W'(1)) && ie_done;
      ev_half <= item_done && ((cnt - CNT_W'(1)) == (cnt_prog >> 1)) && ie_half;
      ev_err  <= err_hit && ie_err;
    end
  end

  // R4: an outstanding request keeps its attributes until accepted
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                               && $stable(m_size) && $stable(m_wdata)));

  // R12: an error response ends the item, no write follows
  p_err_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_err) |=> !m_valid);
endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              periph_req,
  output logic              m_valid,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [31:0]       m_wdata,
  input  logic              m_ready,
  input  logic [31:0]       m_rdata,
  input  logic              m_err,
  output logic              ev_done,
  output logic              ev_half,
  output logic              ev_err,
  output logic [1:0]        prio
);
  logic [CTL_W-1:0]  ctrl;
  logic [CNT_W-1:0]  cnt, cnt_prog;
  logic [ADDR_W-1:0] pbase, mbase;
  logic              item_done, err_hit, wrap, ag_load;

  logic [ADDR_W-1:0] side_base [N_SIDES];
  logic [ADDR_W-1:0] side_addr [N_SIDES];
  logic [1:0]        side_sz   [N_SIDES];
  logic              side_inc  [N_SIDES];

  assign wrap    = item_done && ctrl[CTL_CIRC] && (cnt == CNT_W'(1));
  assign ag_load = !ctrl[CTL_EN] || wrap;

  assign side_base[SIDE_PER] = pbase;
  assign side_base[SIDE_MEM] = mbase;
  assign side_sz[SIDE_PER]   = ctrl[CTL_PSZ +: 2];
  assign side_sz[SIDE_MEM]   = ctrl[CTL_MSZ +: 2];
  assign side_inc[SIDE_PER]  = ctrl[CTL_PINC];
  assign side_inc[SIDE_MEM]  = ctrl[CTL_MINC];

  xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .sel(reg_sel), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .item_done(item_done), .reload(wrap), .err_stop(err_hit),
    .ctrl(ctrl), .cnt(cnt), .cnt_prog(cnt_prog), .pbase(pbase), .mbase(mbase)
  );

  generate
    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
      xfer_addr_gen #(.ADDR_W(ADDR_W)) u_ag (
        .clk(clk), .rst(rst), .load(ag_load), .advance(item_done),
        .inc(side_inc[g]), .size(side_sz[g]), .base(side_base[g]),
        .addr_o(side_addr[g])
      );
    end
  endgenerate

  xfer_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(ctrl[CTL_EN]),
    .trig(ctrl[CTL_M2M] || periph_req), .dir(ctrl[CTL_DIR]),
    .psize(side_sz[SIDE_PER]), .msize(side_sz[SIDE_MEM]),
    .paddr(side_addr[SIDE_PER]), .maddr(side_addr[SIDE_MEM]),
    .cnt(cnt), .cnt_prog(cnt_prog),
    .ie_done(ctrl[CTL_IE_DN]), .ie_half(ctrl[CTL_IE_HF]), .ie_err(ctrl[CTL_IE_ER]),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .item_done(item_done), .err_hit(err_hit),
    .ev_done(ev_done), .ev_half(ev_half), .ev_err(ev_err)
  );

  assign prio = ctrl[CTL_PRIO +: 2];

  // R5: issued addresses respect the access size
  p_align_word_r5: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_size == 2'b10) |-> (m_addr[1:0] == 2'b00));
  p_align_half_r5: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_size == 2'b01) |-> (m_addr[0] == 1'b0));

  // R9: an idle channel with nothing left to move stays idle
  p_idle_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !m_valid) |=> !m_valid);

  // R7: a non-circular done pulse coincides with an empty count
  p_done_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_done && !ctrl[CTL_CIRC]) |-> (cnt == '0));
endmodule

// File: tb/tb_xfer_chan.sv
module tb_xfer_chan;
  localparam int LOGN = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        m_valid, m_write;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_ready = 1'b0;
  logic [31:0] m_rdata = '0;
  logic        m_err = 1'b0;
  logic        ev_done, ev_half, ev_err;
  logic [1:0]  prio;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // bus model state
  bit          stall_en = 1'b0;
  bit          err_arm  = 1'b0;
  logic [31:0] err_addr = '0;
  int          cyc = 0;
  int          rd_n = 0, wr_n = 0;
  int          done_n = 0, half_n = 0, err_n = 0;
  logic [31:0] rd_a [LOGN];
  logic [1:0]  rd_s [LOGN];
  logic [31:0] wr_a [LOGN];
  logic [31:0] wr_d [LOGN];

  xfer_chan dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .periph_req(periph_req), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_ready(m_ready),
    .m_rdata(m_rdata), .m_err(m_err), .ev_done(ev_done), .ev_half(ev_half),
    .ev_err(ev_err), .prio(prio)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction
  function automatic int stp(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction
  function automatic logic [31:0] al(input logic [31:0] a, input logic [1:0] s);
    return (s == 2'b00) ? a : (s == 2'b01) ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
  endfunction
  function automatic logic [31:0] dm(input logic [1:0] s);
    return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] mk(input bit ied, ieh, iee, dir, circ, pinc, minc,
                                     input logic [1:0] psz, msz, pr, input bit m2m);
    return {17'd0, m2m, pr, msz, psz, minc, pinc, circ, dir, iee, ieh, ied, 1'b0};
  endfunction

  // bus responder, acts at falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (m_valid && (!stall_en || cyc[0])) begin
        m_ready = 1'b1;
        if (!m_write) begin
          m_rdata = pat(m_addr);
          m_err   = err_arm && (m_addr == err_addr);
          if (rd_n < LOGN) begin rd_a[rd_n] = m_addr; rd_s[rd_n] = m_size; end
          rd_n++;
        end else begin
          m_err = 1'b0;
          if (wr_n < LOGN) begin wr_a[wr_n] = m_addr; wr_d[wr_n] = m_wdata; end
          wr_n++;
        end
      end else begin
        m_ready = 1'b0;
        m_err   = 1'b0;
      end
      done_n += int'(ev_done);
      half_n += int'(ev_half);
      err_n  += int'(ev_err);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_wr(input int target, input int limit);
    for (int k = 0; k < limit && wr_n < target; k++) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] cfg, input int n, input logic [31:0] pb, mb);
    reg_wr(2'd0, cfg);
    reg_wr(2'd1, 32'(n));
    reg_wr(2'd2, pb);
    reg_wr(2'd3, mb);
  endtask

  // compare logged accesses against arithmetic expectations
  task automatic check_items(input string req, input int r0, w0, iters, n,
                             input logic [31:0] cfg, pb, mb);
    bit          dir = cfg[4];
    logic [1:0]  ssz = dir ? cfg[11:10] : cfg[9:8];
    logic [1:0]  dsz = dir ? cfg[9:8] : cfg[11:10];
    bit          sinc = dir ? cfg[7] : cfg[6];
    bit          dinc = dir ? cfg[6] : cfg[7];
    logic [31:0] sb = dir ? mb : pb;
    logic [31:0] db = dir ? pb : mb;
    for (int i = 0; i < iters; i++) begin
      int j = i % n;
      logic [31:0] ea = al(sb, ssz) + (sinc ? 32'(j * stp(ssz)) : 32'd0);
      logic [31:0] ew = al(db, dsz) + (dinc ? 32'(j * stp(dsz)) : 32'd0);
      chk(req, $sformatf("read addr item %0d", i), rd_a[r0+i], ea);
      chk(req, $sformatf("read size item %0d", i), 32'(rd_s[r0+i]), 32'(ssz));
      chk(req, $sformatf("write addr item %0d", i), wr_a[w0+i], ew);
      chk(req, $sformatf("write data item %0d", i), wr_d[w0+i], pat(ea) & dm(ssz));
    end
  endtask

  initial begin
    logic [31:0] v, cfg;
    int r0, w0, d0, h0, e0;
    tick(3);
    @(negedge clk) rst = 1'b0;
    tick(2);

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      reg_rd(2'(s), v);
      chk("R1", $sformatf("reg %0d after reset", s), v, 32'd0);
    end
    chk("R1", "no request after reset", 32'(m_valid), 32'd0);
    chk("R1", "no events after reset", 32'(done_n + half_n + err_n), 32'd0);

    // R2 and R14: register readback and priority export
    reg_wr(2'd0, 32'h7FFE); reg_rd(2'd0, v);
    chk("R2", "control readback", v, 32'h7FFE);
    chk("R14", "priority 11", 32'(prio), 32'd3);
    reg_wr(2'd0, 32'h1000); tick(1);
    chk("R14", "priority 01", 32'(prio), 32'd1);
    reg_wr(2'd2, 32'hDEAD_BEEF); reg_rd(2'd2, v);
    chk("R2", "peripheral base readback", v, 32'hDEAD_BEEF);
    reg_wr(2'd3, 32'h1234_5678); reg_rd(2'd3, v);
    chk("R2", "memory base readback", v, 32'h1234_5678);
    reg_wr(2'd0, 32'd0);

    // R3 R4 R6 R7 R13: memory to peripheral, words, stalled bus
    stall_en = 1'b1;
    cfg = mk(1,1,1, 1,0,1,1, 2'b10, 2'b10, 2'b00, 1);
    setup(cfg, 4, 32'h0000_8000, 32'h0001_0000);
    r0 = rd_n; w0 = wr_n; d0 = done_n; h0 = half_n;
    reg_wr(2'd0, cfg | 32'd1);
    wait_wr(w0 + 4, 500);
    tick(30);
    chk("R7", "item count, normal mode", 32'(wr_n - w0), 32'd4);
    check_items("R3", r0, w0, 4, 4, cfg, 32'h0000_8000, 32'h0001_0000);
    reg_rd(2'd1, v);  chk("R7", "count after run", v, 32'd0);
    reg_rd(2'd0, v);  chk("R7", "enable kept", v, cfg | 32'd1);
    chk("R7", "one done pulse", 32'(done_n - d0), 32'd1);
    chk("R13", "one half pulse", 32'(half_n - h0), 32'd1);
    reg_wr(2'd0, cfg);
    stall_en = 1'b0;

    // R5 R6 R3: sweep of every size pair from misaligned bases
    for (int ps = 0; ps < 3; ps++) begin
      for (int ms = 0; ms < 3; ms++) begin
        cfg = mk(0,0,0, 0,0,1,1, 2'(ps), 2'(ms), 2'b00, 1);
        setup(cfg, 3, 32'h0000_1003, 32'h0000_2007);
        r0 = rd_n; w0 = wr_n;
        reg_wr(2'd0, cfg | 32'd1);
        wait_wr(w0 + 3, 300);
        tick(5);
        chk("R5", $sformatf("items sizes %0d/%0d", ps, ms), 32'(wr_n - w0), 32'd3);
        check_items("R5", r0, w0, 3, 3, cfg, 32'h0000_1003, 32'h0000_2007);
        reg_wr(2'd0, cfg);
      end
    end

    // R6: peripheral address held, memory incremented
    cfg = mk(0,0,0, 0,0,0,1, 2'b01, 2'b00, 2'b00, 1);
    setup(cfg, 3, 32'h0000_3001, 32'h0000_4000);
    r0 = rd_n; w0 = wr_n;
    reg_wr(2'd0, cfg | 32'd1);
    wait_wr(w0 + 3, 300);
    tick(5);
    check_items("R6", r0, w0, 3, 3, cfg, 32'h0000_3001, 32'h0000_4000);
    reg_wr(2'd0, cfg);

    // R9 R8: zero count stays idle, count write while enabled ignored
    cfg = mk(1,1,1, 0,0,1,1, 2'b10, 2'b10, 2'b00, 1);
    setup(cfg, 0, 32'h0000_5000, 32'h0000_6000);
    r0 = rd_n;
    reg_wr(2'd0, cfg | 32'd1);
    tick(30);
    chk("R9", "no request with zero count", 32'(rd_n - r0), 32'd0);
    reg_wr(2'd1, 32'd5);
    tick(30);
    reg_rd(2'd1, v);
    chk("R8", "count write while enabled", v, 32'd0);
    chk("R9", "still idle after ignored write", 32'(rd_n - r0), 32'd0);
    reg_wr(2'd0, cfg);

    // R10 R8: peripheral request gating and live count
    cfg = mk(0,0,0, 0,0,1,1, 2'b10, 2'b10, 2'b00, 0);
    setup(cfg, 3, 32'h0000_7000, 32'h0000_9000);
    r0 = rd_n; w0 = wr_n;
    reg_wr(2'd0, cfg | 32'd1);
    tick(30);
    chk("R10", "no item without request", 32'(rd_n - r0), 32'd0);
    @(negedge clk) periph_req = 1'b1;
    @(negedge clk) periph_req = 1'b0;
    tick(20);
    chk("R10", "one item per request pulse", 32'(wr_n - w0), 32'd1);
    reg_rd(2'd1, v);  chk("R8", "live count mid-run", v, 32'd2);
    reg_wr(2'd1, 32'd9); reg_rd(2'd1, v);
    chk("R8", "count write ignored mid-run", v, 32'd2);
    @(negedge clk) periph_req = 1'b1;
    wait_wr(w0 + 3, 300);
    @(negedge clk) periph_req = 1'b0;
    tick(10);
    chk("R10", "items with request held", 32'(wr_n - w0), 32'd3);
    check_items("R10", r0, w0, 3, 3, cfg, 32'h0000_7000, 32'h0000_9000);
    reg_wr(2'd0, cfg);

    // R11: circular reload of count and addresses
    cfg = mk(1,0,0, 1,1,1,1, 2'b10, 2'b10, 2'b00, 1);
    setup(cfg, 3, 32'h0000_A000, 32'h0000_B000);
    r0 = rd_n; w0 = wr_n; d0 = done_n;
    reg_wr(2'd0, cfg | 32'd1);
    wait_wr(w0 + 7, 500);
    reg_wr(2'd0, cfg);
    tick(10);
    chk("R11", "kept running past one pass", 32'(wr_n - w0 >= 7), 32'd1);
    check_items("R11", r0, w0, 7, 3, cfg, 32'h0000_A000, 32'h0000_B000);
    chk("R11", "done pulse per pass", 32'(done_n - d0), 32'd2);

    // R12: error on third read
    cfg = mk(1,1,1, 0,0,1,1, 2'b00, 2'b00, 2'b00, 1);
    setup(cfg, 4, 32'h0000_C000, 32'h0000_D000);
    err_addr = 32'h0000_C002; err_arm = 1'b1;
    r0 = rd_n; w0 = wr_n; e0 = err_n;
    reg_wr(2'd0, cfg | 32'd1);
    tick(60);
    chk("R12", "reads issued", 32'(rd_n - r0), 32'd3);
    chk("R12", "writes issued", 32'(wr_n - w0), 32'd2);
    chk("R12", "error pulse", 32'(err_n - e0), 32'd1);
    reg_rd(2'd0, v);  chk("R12", "enable cleared", v, cfg);
    reg_rd(2'd1, v);  chk("R12", "count frozen", v, 32'd2);
    check_items("R12", r0, w0, 2, 4, cfg, 32'h0000_C000, 32'h0000_D000);
    err_arm = 1'b0;

    // R13: pulses gated off, odd count halfway point
    cfg = mk(0,0,0, 0,0,1,1, 2'b10, 2'b10, 2'b00, 1);
    setup(cfg, 2, 32'h0000_E000, 32'h0000_F000);
    w0 = wr_n; d0 = done_n; h0 = half_n;
    reg_wr(2'd0, cfg | 32'd1);
    wait_wr(w0 + 2, 300); tick(10);
    chk("R13", "done gated off", 32'(done_n - d0), 32'd0);
    chk("R13", "half gated off", 32'(half_n - h0), 32'd0);
    cfg = mk(0,1,0, 0,0,1,1, 2'b10, 2'b10, 2'b00, 1);
    setup(cfg, 5, 32'h0000_E000, 32'h0000_F000);
    w0 = wr_n; h0 = half_n;
    reg_wr(2'd0, cfg | 32'd1);
    wait_wr(w0 + 3, 300);
    tick(1);
    chk("R13", "half pulse at 2 of 5", 32'(half_n - h0), 32'd1);
    wait_wr(w0 + 5, 300); tick(10);
    chk("R13", "single half pulse", 32'(half_n - h0), 32'd1);
    reg_wr(2'd0, cfg);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule